// File: doc/BRIEF.md
# Board Control Register Block

This block is a small memory-mapped register file for a processor evaluation board. It sits on a plain 32-bit register bus and has a byte offset, a write strobe with write data, a read strobe and registered read data. Software reads a fixed build identifier and the processor clock rate, which is set when the block is built. It drives a bank of LEDs, reads a bank of DIP switches and can ask the board to reset itself.

The block decodes a 64 KiB offset window, but it implements only five word offsets. The switch pins are asynchronous, so they pass through a synchroniser chain before they are captured. A software reset happens only when the exact key value is written to the reset register. The request leaves the block as a one-cycle pulse that an external reset controller acts on.

Top module: `board_ctrl_regs`

## Requirements
- R1: While reset is asserted and just after it is released, `led_out`, the captured switch value, `bus_rdata` and `sys_rst_req` are all zero.
- R2: A read of offset 0x0000 returns the build identifier 0x09272011.
- R3: A read of offset 0x0004 returns the `CLK_HZ` parameter. Its default of 10,000,000 reads as 0x00989680.
- R4: A write to offset 0x0008 stores the low `LED_W` bits of the data. They appear on `led_out` in the cycle after the write edge, and a read of 0x0008 returns them zero-extended. A 1 bit lights an LED.
- R5: A read of offset 0x000C returns the switch pins zero-extended, with 1 meaning on. A change on `sw_in` is captured on the third rising edge after it. A read sampled on the second edge still returns the old value.
- R6: A write of exactly 0x0000DEAD to offset 0x0010 raises `sys_rst_req` for exactly one cycle, in the cycle after the write edge.
- R7: A write to offset 0x0010 of any other value, such as 0x0000DEAC or 0x0001DEAD, leaves `sys_rst_req` low.
- R8: A read of any offset other than 0x0000, 0x0004, 0x0008 or 0x000C returns zero. This includes 0x0010, unaligned offsets and the top of the window.
- R9: Writes to offsets 0x0000, 0x0004 and 0x000C, and to unmapped offsets, change neither `led_out` nor any value that can be read back.
- R10: `bus_rdata` carries the selected value in the cycle after the edge that samples `bus_rd`. It is zero in every cycle that follows an edge where `bus_rd` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Byte offset within the 64 KiB window |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, sampled on the rising edge |
| bus_rdata | output | 32 | Registered read data, zero when no read was sampled |
| sw_in | input | SW_W | Asynchronous DIP switch pins |
| led_out | output | LED_W | LED drive, 1 lights the LED |
| sys_rst_req | output | 1 | One-cycle board reset request |

## Verification
The assertions assume the bus inputs are stable and known at every rising edge, and that `bus_rd` and `bus_wr` are never unknown once reset is released. The bench drives every bus input on the falling edge and holds it for a whole cycle, so each edge sees settled values. The bench changes `sw_in` only on the falling edge and holds it for several cycles, so the synchroniser latency is exact, with no metastability. The bench treats reads and writes as separate transactions and never issues two reset writes back to back.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

    localparam int unsigned OFS_W = 16;

    localparam logic [OFS_W-1:0] OFS_ID   = 16'h0000;
    localparam logic [OFS_W-1:0] OFS_FREQ = 16'h0004;
    localparam logic [OFS_W-1:0] OFS_LED  = 16'h0008;
    localparam logic [OFS_W-1:0] OFS_SW   = 16'h000C;
    localparam logic [OFS_W-1:0] OFS_KICK = 16'h0010;

    localparam int unsigned NUM_SEL = 5;

    typedef enum logic [2:0] {
        SEL_ID   = 3'd0,
        SEL_FREQ = 3'd1,
        SEL_LED  = 3'd2,
        SEL_SW   = 3'd3,
        SEL_KICK = 3'd4,
        SEL_NONE = 3'd7
    } bcr_sel_e;

    function automatic logic [OFS_W-1:0] sel_offset(input int unsigned idx);
        case (idx)
            0:       return OFS_ID;
            1:       return OFS_FREQ;
            2:       return OFS_LED;
            3:       return OFS_SW;
            default: return OFS_KICK;
        endcase
    endfunction

endpackage

// File: rtl/bcr_sync.sv
module bcr_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain_d [STAGES];
    logic [WIDTH-1:0] chain_q [STAGES];

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[g] <= '0;
            else        chain_q[g] <= chain_d[g];
        end
    end

    assign sync_out = chain_q[STAGES-1];

    // R5: the last stage follows the one before it by one cycle
    if (STAGES > 1) begin : g_chk
        assert_sync_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (chain_q[STAGES-1] == $past(chain_q[STAGES-2])));
    end
endmodule

// File: rtl/bcr_decode.sv
module bcr_decode
    import bcr_pkg::*;
(
    input  logic [OFS_W-1:0] addr,
    output bcr_sel_e         sel
);
    logic [NUM_SEL-1:0] hit;

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_hit
        assign hit[g] = (addr == sel_offset(g));
    end

    always_comb begin
        sel = SEL_NONE;
        for (int i = 0; i < NUM_SEL; i++) begin
            if (hit[i]) sel = bcr_sel_e'(i[2:0]);
        end
    end

    // R8: at most one register matches any offset
    always_comb begin
        assert_one_hit_R8: assert ($onehot0(hit));
    end
endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
    import bcr_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned LED_W      = 8,
    parameter int unsigned SW_W       = 8,
    parameter int unsigned SYNC_STG   = 2,
    parameter int unsigned CLK_HZ     = 10_000_000,
    parameter logic [31:0] BUILD_CODE = 32'h0927_2011,
    parameter logic [31:0] KICK_KEY   = 32'h0000_DEAD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [SW_W-1:0]   sw_in,
    output logic [LED_W-1:0]  led_out,
    output logic              sys_rst_req
);
    localparam logic [DATA_W-1:0] ID_WORD   = DATA_W'(BUILD_CODE);
    localparam logic [DATA_W-1:0] FREQ_WORD = DATA_W'(CLK_HZ);
    localparam logic [DATA_W-1:0] KEY_WORD  = DATA_W'(KICK_KEY);

    typedef struct packed {
        logic [LED_W-1:0]  led;
        logic [SW_W-1:0]   sw;
        logic [DATA_W-1:0] rdata;
        logic              kick;
    } bcr_state_t;

    bcr_state_t st_d, st_q;
    bcr_sel_e   sel;
    logic [SW_W-1:0] sw_sync;
    logic [DATA_W-1:0] rd_mux;

    bcr_decode u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    bcr_sync #(.WIDTH(SW_W), .STAGES(SYNC_STG)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sw_in),
        .sync_out (sw_sync)
    );

    always_comb begin
        case (sel)
            SEL_ID:   rd_mux = ID_WORD;
            SEL_FREQ: rd_mux = FREQ_WORD;
            SEL_LED:  rd_mux = DATA_W'(st_q.led);
            SEL_SW:   rd_mux = DATA_W'(st_q.sw);
            default:  rd_mux = '0;
        endcase
    end

    always_comb begin
        st_d       = st_q;
        st_d.sw    = sw_sync;
        st_d.rdata = bus_rd ? rd_mux : '0;
        st_d.kick  = bus_wr && (sel == SEL_KICK) && (bus_wdata == KEY_WORD);
        if (bus_wr && sel == SEL_LED) begin
            st_d.led = bus_wdata[LED_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata   = st_q.rdata;
    assign led_out     = st_q.led;
    assign sys_rst_req = st_q.kick;

    // R10: no read sampled means zero read data
    assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> (bus_rdata == '0));

    // R2: identifier read returns the build code
    assert_id_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && bus_addr == OFS_ID) |-> (bus_rdata == ID_WORD));

    // R9: LEDs move only after a write to the LED offset
    assert_led_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_wr && bus_addr == OFS_LED) |-> $stable(led_out));

    // R6: a reset request follows only a keyed write to the reset offset
    assert_kick_key_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> $past(bus_wr && bus_addr == OFS_KICK && bus_wdata == KEY_WORD));

    // R7: a reset-offset write with the wrong value leaves the request low
    assert_kick_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_wr && bus_addr == OFS_KICK && bus_wdata != KEY_WORD) |-> !sys_rst_req);
endmodule

// File: tb/board_ctrl_regs_bench.sv
`timescale 1ns/1ps
module board_ctrl_regs_bench;
    localparam int unsigned LED_W = 8;
    localparam int unsigned SW_W  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [SW_W-1:0]  sw_in = '0;
    logic [LED_W-1:0] led_out;
    logic        sys_rst_req;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] val;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    board_ctrl_regs u_board_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .sw_in(sw_in), .led_out(led_out), .sys_rst_req(sys_rst_req)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per sampled read, else expects zero
    logic rd_seen = 1'b0;
    always @(posedge clk) rd_seen <= bus_rd & rst_n;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rd_seen) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R10 unexpected read", bus_rdata, 32'h0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(bus_rdata == e.val, e.tag, bus_rdata, e.val);
                end
            end else begin
                check(bus_rdata == 32'h0, "R10 idle rdata", bus_rdata, 32'h0);
            end
        end
    end

    task automatic do_read(input logic [15:0] a, input logic [31:0] exp, input string tag);
        exp_t e;
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        e.val = exp; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic do_write(input logic [15:0] a, input logic [31:0] d,
                            input bit kick_exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check(sys_rst_req == kick_exp, tag, {31'h0, sys_rst_req}, {31'h0, kick_exp});
        @(negedge clk);
        check(sys_rst_req == 1'b0, {tag, " single"}, {31'h0, sys_rst_req}, 32'h0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        check(1'b0, "watchdog", 32'h0, 32'h0);
        finish_run();
    end

    initial begin
        sw_in = 8'hA5;
        idle(4);
        // R1: reset state
        check(led_out == '0, "R1 led", 32'(led_out), 32'h0);
        check(bus_rdata == '0, "R1 rdata", bus_rdata, 32'h0);
        check(sys_rst_req == 1'b0, "R1 kick", {31'h0, sys_rst_req}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        check(led_out == '0, "R1 led after release", 32'(led_out), 32'h0);

        do_read(16'h0000, 32'h0927_2011, "R2 build id");
        do_read(16'h0004, 32'h0098_9680, "R3 clock rate");
        do_read(16'h0008, 32'h0, "R1 led reg after reset");

        // R4: LED writes
        do_write(16'h0008, 32'hFFFF_FF3C, 1'b0, "R4 led write no kick");
        check(led_out == 8'h3C, "R4 led drive", 32'(led_out), 32'h3C);
        do_read(16'h0008, 32'h0000_003C, "R4 led readback");
        do_write(16'h0008, 32'h0000_00C1, 1'b0, "R4 led write2");
        do_read(16'h0008, 32'h0000_00C1, "R4 led readback2");

        // R5: switches (0xA5 held through reset, settled now)
        do_read(16'h000C, 32'h0000_00A5, "R5 switches");
        @(negedge clk);
        sw_in = 8'h5A;
        @(negedge clk);
        bus_addr = 16'h000C; bus_rd = 1'b1;  // sampled on second edge after change
        begin exp_t e; e.val = 32'hA5; e.tag = "R5 old value at edge 2"; sb.push_back(e); end
        @(negedge clk);
        bus_rd = 1'b0;
        @(negedge clk);
        do_read(16'h000C, 32'h0000_005A, "R5 new value");

        // R8: unmapped reads
        do_read(16'h0010, 32'h0, "R8 reset reg read");
        do_read(16'h0014, 32'h0, "R8 offset 0x14");
        do_read(16'h0002, 32'h0, "R8 unaligned");
        do_read(16'hFFFC, 32'h0, "R8 window top");

        // R9: ignored writes
        do_write(16'h0000, 32'h1234_5678, 1'b0, "R9 write id");
        do_write(16'h0004, 32'h0000_0001, 1'b0, "R9 write freq");
        do_write(16'h000C, 32'h0000_00FF, 1'b0, "R9 write sw");
        do_write(16'h0020, 32'h0000_00FF, 1'b0, "R9 write unmapped");
        do_write(16'h0009, 32'h0000_00FF, 1'b0, "R9 write unaligned led");
        check(led_out == 8'hC1, "R9 led unchanged", 32'(led_out), 32'hC1);
        do_read(16'h0000, 32'h0927_2011, "R9 id unchanged");
        do_read(16'h0004, 32'h0098_9680, "R9 freq unchanged");
        do_read(16'h000C, 32'h0000_005A, "R9 sw unchanged");
        do_read(16'h0008, 32'h0000_00C1, "R9 led reg unchanged");

        // R7: wrong keys
        do_write(16'h0010, 32'h0000_DEAC, 1'b0, "R7 near key");
        do_write(16'h0010, 32'h0001_DEAD, 1'b0, "R7 upper bits set");
        do_write(16'h0014, 32'h0000_DEAD, 1'b0, "R7 key at wrong offset");
        // R6: exact key
        do_write(16'h0010, 32'h0000_DEAD, 1'b1, "R6 keyed reset");
        check(led_out == 8'hC1, "R6 leds kept", 32'(led_out), 32'hC1);

        idle(3);
        check(sb.size() == 0, "R10 scoreboard drained", 32'(sb.size()), 32'h0);
        finish_run();
    end
endmodule